// File: doc/BRIEF.md
# Shared-Pool Linked Multi-Queue Buffer

This block keeps six independent first-in first-out queues of 128-bit chunks inside one shared chunk memory. The memory is cut into 128 blocks of eight chunks. A queue owns a singly linked chain of blocks. The links sit in a separate table indexed by block number, so the chunk memory holds data only. Blocks move between a common free list and the queues one whole block at a time. A queue that fills quickly can therefore borrow capacity that an idle queue is not using. Each queue feeds its own consumer, so the queues drain in any order relative to one another, while chunks inside one queue always leave in arrival order.

One push and one pop can be accepted per cycle. Each names its queue by id. Popped data comes back one cycle after the pop is accepted. Each end of a queue (read and write) keeps a 3-bit chunk offset and two block registers, called *first* and *second*. The offset picks the active block. When the offset is in the upper half of a block (4 to 7), *first* is active; when it is in the lower half (0 to 3), *second* is active. The *second* register is loaded with the successor block at the wrap from offset 7 to 0. The reader returns the block it has left to the free list once it is half way into the next block.

Control is a two-state machine. `ST_FILL` is entered on reset and loads the free list with every block that no queue owns, one block per cycle. On the cycle that loads the last block id, the transition `ST_FILL -> ST_RUN` is taken. `ST_RUN` accepts traffic and holds until the next reset, which is the only transition out of it.

Top module: `lnk_qpool`

## Requirements
- R1: After reset is released, the block stays in the fill phase for NUM_BLK-NUM_Q cycles, loading blocks NUM_Q to NUM_BLK-1 into the free list in ascending order. During this phase `push_ready` is low and every pop is flagged. `push_ready` (for a valid queue id) is first high after NUM_BLK-NUM_Q rising edges. At that point `pool_free` is NUM_BLK-NUM_Q, every queue is empty, and queue q owns exactly block q, which is both its first and its second block at each end.
- R2: A pop that is accepted returns, on the next cycle, `pop_rvalid` high and `pop_data` equal to the oldest chunk not yet popped from that queue.
- R3: Interleaved traffic on different queues never reorders or mixes data: every queue keeps its own arrival order.
- R4: A push that writes offset 7 of its block takes the head of the free list. It links that block after the current one, raises the queue's block count by one and lowers `pool_free` by one. The free list hands out blocks in first-in first-out order.
- R5: A pop that moves the read offset from 3 to 4 returns the read-side first block to the tail of the free list if it differs from the second block. The queue's block count then drops by one and `pool_free` rises by one.
- R6: In the run phase, `pool_free` plus the sum of all per-queue block counts always equals NUM_BLK.
- R7: The offset at each end equals the number of chunks pushed (or popped) modulo 8. A move from offset 3 to 4 copies second into first. The wrap from 7 to 0 loads second with the new block (write side) or with the linked successor (read side).
- R8: `q_full[q]` is high when the write offset of q is 7 and `pool_free` is 0. A push to a full queue, or to an id of NUM_Q or above, sees `push_ready` low and changes no state.
- R9: A pop of an empty queue, or of an id of NUM_Q or above, is ignored. One cycle later `pop_err` is high and `pop_rvalid` is low, and no level, pointer or count changes.
- R10: `q_level` holds each queue's chunk count in an 11-bit field; queue q sits at bits [11q+10:11q]. `q_empty[q]` is high exactly when the read and write positions of q coincide, which is when its level is 0.
- R11: The debug outputs show, without delay, the first and second block registers and the offsets of both ends of the queue selected by `dbg_q`, and that queue's block count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Push request |
| push_q | input | 3 | Queue id of the push |
| push_data | input | 128 | Chunk to append |
| push_ready | output | 1 | Push to `push_q` would be accepted this cycle |
| pop_valid | input | 1 | Pop request |
| pop_q | input | 3 | Queue id of the pop |
| pop_rvalid | output | 1 | `pop_data` holds a popped chunk (one cycle after acceptance) |
| pop_data | output | 128 | Popped chunk |
| pop_err | output | 1 | The previous cycle's pop was refused |
| q_empty | output | 6 | Per-queue empty flag |
| q_full | output | 6 | Per-queue full flag |
| q_level | output | 66 | Per-queue chunk count, 11 bits per queue |
| pool_free | output | 8 | Number of blocks in the free list |
| dbg_q | input | 3 | Queue selected for the debug view |
| dbg_rd_first | output | 7 | Read-side first block register |
| dbg_rd_second | output | 7 | Read-side second block register |
| dbg_rd_off | output | 3 | Read chunk offset |
| dbg_wr_first | output | 7 | Write-side first block register |
| dbg_wr_second | output | 7 | Write-side second block register |
| dbg_wr_off | output | 3 | Write chunk offset |
| dbg_blk_cnt | output | 8 | Blocks held by the selected queue |

## Verification
The bench drives one queue until the whole pool is used up and expects exactly 983 chunks to be accepted before it refuses. If allocation came one chunk early or late, or if a block leaked, that count would be wrong. The bench follows one queue through its first block crossing and checks the exact block ids in the first and second registers. Using the wrong half-block rule, or loading second from the wrong source, would show up as a wrong id, and later as data read from the wrong block. Random interleaved traffic is then compared against a reference queue per queue, together with block counts predicted from the push and pop totals. A release that fired at the wrong offset, or that fired when first and second were the same block, would break the conservation sum. Pops of empty queues and of ids above five must raise the error flag and leave every level unchanged.

// File: rtl/lnk_qpool_pkg.sv
package lnk_qpool_pkg;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } pool_state_e;

endpackage

// File: rtl/lnk_qpool_freelist.sv
module lnk_qpool_freelist #(
    parameter  int NUM_BLK = 128,
    localparam int BLK_W   = $clog2(NUM_BLK),
    localparam int CNT_W   = $clog2(NUM_BLK + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    output logic [BLK_W-1:0] head_id,
    output logic             empty,
    input  logic             put,
    input  logic [BLK_W-1:0] put_id,
    output logic [CNT_W-1:0] count
);

    localparam logic [BLK_W-1:0] LAST_SLOT = BLK_W'(NUM_BLK - 1);

    logic [BLK_W-1:0] slots [NUM_BLK];
    logic [BLK_W-1:0] rd_ptr, wr_ptr;

    function automatic logic [BLK_W-1:0] step_ptr(input logic [BLK_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (put) begin
            slots[wr_ptr] <= put_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (take) begin
                rd_ptr <= step_ptr(rd_ptr);
            end
            if (put) begin
                wr_ptr <= step_ptr(wr_ptr);
            end
            count <= count + CNT_W'(put) - CNT_W'(take);
        end
    end

    assign head_id = slots[rd_ptr];
    assign empty   = (count == '0);

endmodule

// File: rtl/lnk_qpool_chunkram.sv
module lnk_qpool_chunkram #(
    parameter  int DEPTH  = 1024,
    parameter  int WIDTH  = 128,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        if (re) begin
            rdata <= cells[raddr];
        end
    end

endmodule

// File: rtl/lnk_qpool_linkram.sv
module lnk_qpool_linkram #(
    parameter  int NUM_BLK = 128,
    localparam int BLK_W   = $clog2(NUM_BLK)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [BLK_W-1:0] waddr,
    input  logic [BLK_W-1:0] wdata,
    input  logic [BLK_W-1:0] raddr,
    output logic [BLK_W-1:0] rdata
);

    logic [BLK_W-1:0] succ [NUM_BLK];

    always_ff @(posedge clk) begin
        if (we) begin
            succ[waddr] <= wdata;
        end
    end

    assign rdata = succ[raddr];

endmodule

// File: rtl/lnk_qpool.sv
module lnk_qpool
    import lnk_qpool_pkg::*;
#(
    parameter  int NUM_Q      = 6,
    parameter  int CHUNK_W    = 128,
    parameter  int BLK_CHUNKS = 8,
    parameter  int NUM_BLK    = 128,
    localparam int QW         = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int OFF_W      = $clog2(BLK_CHUNKS),
    localparam int BLK_W      = $clog2(NUM_BLK),
    localparam int LVL_W      = $clog2(NUM_BLK * BLK_CHUNKS + 1),
    localparam int CNT_W      = $clog2(NUM_BLK + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push_valid,
    input  logic [QW-1:0]          push_q,
    input  logic [CHUNK_W-1:0]     push_data,
    output logic                   push_ready,
    input  logic                   pop_valid,
    input  logic [QW-1:0]          pop_q,
    output logic                   pop_rvalid,
    output logic [CHUNK_W-1:0]     pop_data,
    output logic                   pop_err,
    output logic [NUM_Q-1:0]       q_empty,
    output logic [NUM_Q-1:0]       q_full,
    output logic [NUM_Q*LVL_W-1:0] q_level,
    output logic [CNT_W-1:0]       pool_free,
    input  logic [QW-1:0]          dbg_q,
    output logic [BLK_W-1:0]       dbg_rd_first,
    output logic [BLK_W-1:0]       dbg_rd_second,
    output logic [OFF_W-1:0]       dbg_rd_off,
    output logic [BLK_W-1:0]       dbg_wr_first,
    output logic [BLK_W-1:0]       dbg_wr_second,
    output logic [OFF_W-1:0]       dbg_wr_off,
    output logic [CNT_W-1:0]       dbg_blk_cnt
);

    localparam int ADDR_W = BLK_W + OFF_W;
    localparam logic [OFF_W-1:0] OFF_HALF = OFF_W'(BLK_CHUNKS / 2);
    localparam logic [OFF_W-1:0] OFF_PRE  = OFF_W'(BLK_CHUNKS / 2 - 1);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(BLK_CHUNKS - 1);
    localparam logic [QW-1:0]    Q_MAX    = QW'(NUM_Q - 1);

    // ---------------- control state machine ----------------
    pool_state_e      state_q, state_d;
    logic             run, filling;
    logic [BLK_W-1:0] fill_id_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_FILL;
            fill_id_q <= BLK_W'(NUM_Q);
        end else begin
            state_q <= state_d;
            if (filling) begin
                fill_id_q <= fill_id_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        run     = 1'b0;
        filling = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                filling = 1'b1;
                if (fill_id_q == BLK_W'(NUM_BLK - 1)) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                run = 1'b1;
            end
        endcase
    end

    // ---------------- per-queue pointer state ----------------
    logic [BLK_W-1:0] rd_a [NUM_Q];
    logic [BLK_W-1:0] rd_b [NUM_Q];
    logic [BLK_W-1:0] wr_a [NUM_Q];
    logic [BLK_W-1:0] wr_b [NUM_Q];
    logic [OFF_W-1:0] rd_off [NUM_Q];
    logic [OFF_W-1:0] wr_off [NUM_Q];
    logic [BLK_W-1:0] rd_cur [NUM_Q];
    logic [BLK_W-1:0] wr_cur [NUM_Q];
    logic [LVL_W-1:0] lvl [NUM_Q];
    logic [CNT_W-1:0] bcnt [NUM_Q];
    logic [NUM_Q*CNT_W-1:0] blk_cnt_flat;

    // ---------------- request decode ----------------
    logic             push_q_ok, pop_q_ok, dbg_q_ok;
    logic [QW-1:0]    wsel, rsel, dsel;
    logic             push_do, pop_do, alloc, release_blk;
    logic [BLK_W-1:0] fl_head, link_rdata;
    logic             fl_empty;

    assign push_q_ok = (push_q <= Q_MAX);
    assign pop_q_ok  = (pop_q <= Q_MAX);
    assign dbg_q_ok  = (dbg_q <= Q_MAX);
    assign wsel      = push_q_ok ? push_q : '0;
    assign rsel      = pop_q_ok ? pop_q : '0;
    assign dsel      = dbg_q_ok ? dbg_q : '0;

    assign push_ready  = run && push_q_ok && !q_full[wsel];
    assign push_do     = push_valid && push_ready;
    assign alloc       = push_do && (wr_off[wsel] == OFF_LAST);
    assign pop_do      = run && pop_valid && pop_q_ok && !q_empty[rsel];
    assign release_blk = pop_do && (rd_off[rsel] == OFF_PRE) && (rd_a[rsel] != rd_b[rsel]);

    for (genvar i = 0; i < NUM_Q; i++) begin : g_queue
        logic [BLK_W-1:0] ra, rb, wa, wb;
        logic [OFF_W-1:0] ro, wo;
        logic [LVL_W-1:0] lv;
        logic [CNT_W-1:0] bc;
        logic             psh, pp;

        assign psh = push_do && (push_q == QW'(i));
        assign pp  = pop_do && (pop_q == QW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ra <= BLK_W'(i);
                rb <= BLK_W'(i);
                wa <= BLK_W'(i);
                wb <= BLK_W'(i);
                ro <= '0;
                wo <= '0;
                lv <= '0;
                bc <= CNT_W'(1);
            end else begin
                if (psh) begin
                    wo <= wo + 1'b1;
                    if (wo == OFF_PRE) begin
                        wa <= wb;
                    end
                    if (wo == OFF_LAST) begin
                        wb <= fl_head;
                    end
                end
                if (pp) begin
                    ro <= ro + 1'b1;
                    if (ro == OFF_PRE) begin
                        ra <= rb;
                    end
                    if (ro == OFF_LAST) begin
                        rb <= link_rdata;
                    end
                end
                lv <= lv + LVL_W'(psh) - LVL_W'(pp);
                bc <= bc + CNT_W'(psh && (wo == OFF_LAST))
                         - CNT_W'(pp && (ro == OFF_PRE) && (ra != rb));
            end
        end

        assign rd_a[i]   = ra;
        assign rd_b[i]   = rb;
        assign wr_a[i]   = wa;
        assign wr_b[i]   = wb;
        assign rd_off[i] = ro;
        assign wr_off[i] = wo;
        assign lvl[i]    = lv;
        assign bcnt[i]   = bc;
        assign rd_cur[i] = (ro >= OFF_HALF) ? ra : rb;
        assign wr_cur[i] = (wo >= OFF_HALF) ? wa : wb;

        assign q_empty[i] = (rd_cur[i] == wr_cur[i]) && (ro == wo);
        assign q_full[i]  = (wo == OFF_LAST) && fl_empty;
        assign q_level[i*LVL_W +: LVL_W]      = lv;
        assign blk_cnt_flat[i*CNT_W +: CNT_W] = bc;
    end

    // ---------------- shared storage ----------------
    lnk_qpool_freelist #(.NUM_BLK(NUM_BLK)) u_free (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (alloc),
        .head_id (fl_head),
        .empty   (fl_empty),
        .put     (filling || release_blk),
        .put_id  (filling ? fill_id_q : rd_a[rsel]),
        .count   (pool_free)
    );

    lnk_qpool_linkram #(.NUM_BLK(NUM_BLK)) u_link (
        .clk   (clk),
        .we    (alloc),
        .waddr (wr_cur[wsel]),
        .wdata (fl_head),
        .raddr (rd_a[rsel]),
        .rdata (link_rdata)
    );

    lnk_qpool_chunkram #(.DEPTH(NUM_BLK * BLK_CHUNKS), .WIDTH(CHUNK_W)) u_data (
        .clk   (clk),
        .we    (push_do),
        .waddr (ADDR_W'({wr_cur[wsel], wr_off[wsel]})),
        .wdata (push_data),
        .re    (pop_do),
        .raddr (ADDR_W'({rd_cur[rsel], rd_off[rsel]})),
        .rdata (pop_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pop_rvalid <= 1'b0;
            pop_err    <= 1'b0;
        end else begin
            pop_rvalid <= pop_do;
            pop_err    <= pop_valid && !pop_do;
        end
    end

    // ---------------- debug view ----------------
    assign dbg_rd_first  = rd_a[dsel];
    assign dbg_rd_second = rd_b[dsel];
    assign dbg_rd_off    = rd_off[dsel];
    assign dbg_wr_first  = wr_a[dsel];
    assign dbg_wr_second = wr_b[dsel];
    assign dbg_wr_off    = wr_off[dsel];
    assign dbg_blk_cnt   = bcnt[dsel];

endmodule

// File: rtl/lnk_qpool_chk.sv
module lnk_qpool_chk #(
    parameter int NUM_Q   = 6,
    parameter int QW      = 3,
    parameter int LVL_W   = 11,
    parameter int CNT_W   = 8,
    parameter int NUM_BLK = 128
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   run,
    input logic                   push_valid,
    input logic [QW-1:0]          push_q,
    input logic                   push_ready,
    input logic                   pop_valid,
    input logic [QW-1:0]          pop_q,
    input logic                   pop_rvalid,
    input logic                   pop_err,
    input logic [NUM_Q-1:0]       q_empty,
    input logic [NUM_Q-1:0]       q_full,
    input logic [NUM_Q*LVL_W-1:0] q_level,
    input logic [CNT_W-1:0]       pool_free,
    input logic [NUM_Q*CNT_W-1:0] blk_cnt_flat
);

    int held_total;

    always_comb begin
        held_total = int'(pool_free);
        for (int q = 0; q < NUM_Q; q++) begin
            held_total += int'(blk_cnt_flat[q*CNT_W +: CNT_W]);
        end
    end

    a_r1_fill_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !push_ready);

    a_r6_conservation: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (held_total == NUM_BLK));

    a_r9_bad_id_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && (pop_q > QW'(NUM_Q - 1))) |=> (pop_err && !pop_rvalid));

    for (genvar i = 0; i < NUM_Q; i++) begin : g_chk
        a_r2_pop_returns: assert property (@(posedge clk) disable iff (!rst_n)
            (run && pop_valid && (pop_q == QW'(i)) && !q_empty[i]) |=> (pop_rvalid && !pop_err));

        a_r9_empty_pop_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_valid && (pop_q == QW'(i)) && q_empty[i]) |=> (pop_err && !pop_rvalid));

        a_r10_empty_matches_level: assert property (@(posedge clk) disable iff (!rst_n)
            run |-> (q_empty[i] == (q_level[i*LVL_W +: LVL_W] == '0)));

        a_r8_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
            (q_full[i] && (push_q == QW'(i))) |-> !push_ready);

        a_r8_refused_holds_level: assert property (@(posedge clk) disable iff (!rst_n)
            (push_valid && (push_q == QW'(i)) && !push_ready && !(pop_valid && (pop_q == QW'(i))))
            |=> $stable(q_level[i*LVL_W +: LVL_W]));
    end

endmodule

bind lnk_qpool lnk_qpool_chk #(
    .NUM_Q   (NUM_Q),
    .QW      (QW),
    .LVL_W   (LVL_W),
    .CNT_W   (CNT_W),
    .NUM_BLK (NUM_BLK)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .push_valid   (push_valid),
    .push_q       (push_q),
    .push_ready   (push_ready),
    .pop_valid    (pop_valid),
    .pop_q        (pop_q),
    .pop_rvalid   (pop_rvalid),
    .pop_err      (pop_err),
    .q_empty      (q_empty),
    .q_full       (q_full),
    .q_level      (q_level),
    .pool_free    (pool_free),
    .blk_cnt_flat (blk_cnt_flat)
);

// File: tb/lnk_qpool_tb_top.sv
module lnk_qpool_tb_top;

    localparam int NQ = 6;
    localparam int NB = 128;
    localparam int LW = 11;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           push_valid = 1'b0;
    logic [2:0]     push_q = '0;
    logic [127:0]   push_data = '0;
    logic           push_ready;
    logic           pop_valid = 1'b0;
    logic [2:0]     pop_q = '0;
    logic           pop_rvalid;
    logic [127:0]   pop_data;
    logic           pop_err;
    logic [NQ-1:0]  q_empty, q_full;
    logic [NQ*LW-1:0] q_level;
    logic [7:0]     pool_free;
    logic [2:0]     dbg_q = '0;
    logic [6:0]     dbg_rd_first, dbg_rd_second, dbg_wr_first, dbg_wr_second;
    logic [2:0]     dbg_rd_off, dbg_wr_off;
    logic [7:0]     dbg_blk_cnt;

    always #10 clk = ~clk;

    lnk_qpool dut_i (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_q(push_q), .push_data(push_data), .push_ready(push_ready),
        .pop_valid(pop_valid), .pop_q(pop_q), .pop_rvalid(pop_rvalid), .pop_data(pop_data),
        .pop_err(pop_err), .q_empty(q_empty), .q_full(q_full), .q_level(q_level),
        .pool_free(pool_free), .dbg_q(dbg_q),
        .dbg_rd_first(dbg_rd_first), .dbg_rd_second(dbg_rd_second), .dbg_rd_off(dbg_rd_off),
        .dbg_wr_first(dbg_wr_first), .dbg_wr_second(dbg_wr_second), .dbg_wr_off(dbg_wr_off),
        .dbg_blk_cnt(dbg_blk_cnt)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [127:0] ref_q [NQ][$];
    int pushes [NQ];
    int pops [NQ];
    int seq = 0;
    int rot = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int releases(input int r);
        return (r >= 12) ? ((r - 12) / 8 + 1) : 0;
    endfunction

    function automatic int exp_bc(input int q);
        return 1 + pushes[q] / 8 - releases(pops[q]);
    endfunction

    function automatic int exp_free();
        int s = NB;
        for (int q = 0; q < NQ; q++) s -= exp_bc(q);
        return s;
    endfunction

    function automatic bit exp_full(input int q);
        return (exp_free() == 0) && (pushes[q] % 8 == 7);
    endfunction

    function automatic logic [127:0] mk(input int q, input int s);
        return {8'(q), 24'(s), 32'(s * 40503), 32'(~s), 32'(s ^ 32'h5A5A_C3C3)};
    endfunction

    task automatic check_state();
        logic [NQ*LW-1:0] lv_e;
        logic [NQ-1:0] em_e, fu_e;
        for (int q = 0; q < NQ; q++) begin
            lv_e[q*LW +: LW] = LW'(pushes[q] - pops[q]);
            em_e[q] = (pushes[q] == pops[q]);
            fu_e[q] = exp_full(q);
        end
        check(q_level == lv_e, "R10", "levels", 128'(q_level), 128'(lv_e));
        check(q_empty == em_e, "R10", "empty flags", 128'(q_empty), 128'(em_e));
        check(q_full == fu_e, "R8", "full flags", 128'(q_full), 128'(fu_e));
        check(int'(pool_free) == exp_free(), "R6", "free count", 128'(pool_free), 128'(exp_free()));
        dbg_q = 3'(rot);
        #1;
        check(int'(dbg_blk_cnt) == exp_bc(rot), "R4/R5", "block count", 128'(dbg_blk_cnt), 128'(exp_bc(rot)));
        check(int'(dbg_wr_off) == pushes[rot] % 8, "R11", "write offset", 128'(dbg_wr_off), 128'(pushes[rot] % 8));
        check(int'(dbg_rd_off) == pops[rot] % 8, "R11", "read offset", 128'(dbg_rd_off), 128'(pops[rot] % 8));
        rot = (rot + 1) % NQ;
    endtask

    // one cycle: optional push and optional pop, driven at the falling edge
    task automatic step(input bit pv, input int pq, input bit ov, input int oq);
        logic [127:0] d, expd;
        bit pacc, oacc, rdy_e;
        d = mk(pq, seq);
        expd = '0;
        push_valid = pv;
        push_q = 3'(pq);
        push_data = d;
        pop_valid = ov;
        pop_q = 3'(oq);
        rdy_e = (pq < NQ) && !exp_full(pq);
        pacc = pv && rdy_e;
        oacc = ov && (oq < NQ) && (ref_q[oq].size() > 0);
        #1;
        if (pv) check(push_ready == rdy_e, "R8", "push_ready", 128'(push_ready), 128'(rdy_e));
        @(posedge clk);
        if (pacc) begin
            ref_q[pq].push_back(d);
            pushes[pq]++;
            seq++;
        end
        if (oacc) begin
            expd = ref_q[oq].pop_front();
            pops[oq]++;
        end
        @(negedge clk);
        push_valid = 1'b0;
        pop_valid = 1'b0;
        check(pop_rvalid == oacc, "R2", "pop_rvalid", 128'(pop_rvalid), 128'(oacc));
        check(pop_err == (ov && !oacc), "R9", "pop_err", 128'(pop_err), 128'(ov && !oacc));
        if (oacc) check(pop_data == expd, "R2/R3", "pop data", pop_data, expd);
        check_state();
    endtask

    initial begin
        int k;
        for (int q = 0; q < NQ; q++) begin
            pushes[q] = 0;
            pops[q] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: fill phase length, then reset state
        k = 0;
        for (int c = 0; c < 400; c++) begin
            @(posedge clk);
            @(negedge clk);
            k++;
            if (push_ready) break;
        end
        check(k == NB - NQ, "R1", "cycles until push_ready", 128'(k), 128'(NB - NQ));
        dbg_q = 3'd4;
        #1;
        check(dbg_rd_first == 7'd4 && dbg_rd_second == 7'd4 && dbg_wr_first == 7'd4 && dbg_wr_second == 7'd4,
              "R1", "initial blocks of queue 4", 128'({dbg_rd_first, dbg_rd_second, dbg_wr_first, dbg_wr_second}),
              128'({7'd4, 7'd4, 7'd4, 7'd4}));
        check_state();

        // R7: pointer registers across the first block crossing of queue 2
        for (int i = 0; i < 8; i++) step(1, 2, 0, 0);
        dbg_q = 3'd2;
        #1;
        check(dbg_wr_first == 7'd2 && dbg_wr_second == 7'd6, "R7", "write first/second after wrap",
              128'({dbg_wr_first, dbg_wr_second}), 128'({7'd2, 7'd6}));
        for (int i = 0; i < 4; i++) step(1, 2, 0, 0);
        dbg_q = 3'd2;
        #1;
        check(dbg_wr_first == 7'd6 && dbg_wr_second == 7'd6, "R7", "write first/second past half",
              128'({dbg_wr_first, dbg_wr_second}), 128'({7'd6, 7'd6}));
        for (int i = 0; i < 8; i++) step(0, 0, 1, 2);
        dbg_q = 3'd2;
        #1;
        check(dbg_rd_first == 7'd2 && dbg_rd_second == 7'd6, "R7", "read first/second after wrap",
              128'({dbg_rd_first, dbg_rd_second}), 128'({7'd2, 7'd6}));
        for (int i = 0; i < 4; i++) step(0, 0, 1, 2);
        dbg_q = 3'd2;
        #1;
        check(dbg_rd_first == 7'd6 && dbg_rd_second == 7'd6, "R5", "read first after release",
              128'({dbg_rd_first, dbg_rd_second}), 128'({7'd6, 7'd6}));

        // R9: pops of an empty queue and of an unused id
        step(0, 0, 1, 3);
        step(0, 0, 1, 7);

        // R4/R8: exhaust the pool with queue 0
        k = 0;
        while (!exp_full(0) && k < 2000) begin
            step(1, 0, 0, 0);
            k++;
        end
        check(k == (NB - NQ) * 8 + 7, "R4", "chunks accepted before exhaustion", 128'(k), 128'((NB - NQ) * 8 + 7));
        step(1, 0, 0, 0);
        for (int i = 0; i < 8; i++) step(1, 1, 0, 0);
        step(1, 6, 0, 0);

        // drain both queues in order
        while (ref_q[0].size() > 0) step(0, 0, 1, 0);
        while (ref_q[1].size() > 0) step(0, 0, 1, 1);

        // R3: random interleaved traffic on all queues
        for (int i = 0; i < 6000; i++) begin
            step($urandom_range(0, 99) < 55, int'($urandom_range(0, 6)),
                 $urandom_range(0, 99) < 50, int'($urandom_range(0, 7)));
        end
        for (int q = 0; q < NQ; q++) begin
            while (ref_q[q].size() > 0) step(0, 0, 1, q);
        end
        check(int'(pool_free) == exp_free(), "R6", "final free count", 128'(pool_free), 128'(exp_free()));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule